// File: doc/BRIEF.md
# Critical-Band Analysis Sequencer

This block is the control half of a critical-band spectral analyser. A frame of speech samples sits in an input RAM. The analyser works through a fixed list of frequency bands, one after another. Each band correlates a window of the frame with a band-specific kernel. A window length is symmetric about its centre, so samples `n` and `N-n` share one butterfly: their sum feeds the cosine product and their difference feeds the sine product. The sequencer produces the two input-RAM read addresses for each butterfly, a coefficient ROM address and the strobes an external multiply-accumulate datapath needs. When the datapath signals that a band's sums are complete, the sequencer writes the real and imaginary words to the result RAM.

Band parameters are computed at elaboration from a small set of parameters and held in a per-band table. The table gives each band's window length, its parity, its butterfly count and its coefficient base. The first group of bands shares one constant window length. Each later band shortens the window by a fixed ratio, which keeps the quality factor roughly constant. While the sequencer is idle, it acts as the I/O port of the memories: it hands out sequential sample-write addresses and sequential result-read addresses.

Top module: `cbt_band_sequencer`

## Requirements
- R1: After reset `busy`, `done`, `smp_rd_en`, `coef_en`, `res_wr_en`, `smp_wr_en` and `res_rd_en` are 0, and `smp_wr_addr` and `res_rd_addr` are 0.
- R2: Band k (0-based) has window length N = CW_LEN for k < CW_BANDS. After that the first length is CQ_FIRST_LEN, and each next band's length is floor(previous × RATIO_NUM / RATIO_DEN). With the defaults this gives 160 (×5), 158, 148, 138, 129, 120, 112, 105, 98, 91, 85, 79, 74, 69, 64, 60, 56. A band runs floor(N/2)+1 butterflies, one per cycle with `smp_rd_en` high.
- R3: The first butterfly of a band reads one sample. `dp_first`=1, `smp_addr_a`=0, `smp_pair`=0 and `smp_addr_b`=0.
- R4: Butterfly b (0 < b < last) drives `smp_addr_a`=b, `smp_addr_b`=N−b and `smp_pair`=1.
- R5: The last butterfly has `dp_last`=1. For odd N it reads the pair (N−1)/2 and (N+1)/2. For even N it reads only the middle sample N/2, with `smp_pair`=0 and `smp_addr_b`=0.
- R6: `coef_addr` is 0 on the first butterfly of band 0. It rises by 1 on every butterfly, including across band boundaries, so each band starts where the previous band ended. `coef_en` is high only during butterflies.
- R7: After the last butterfly the block waits for `dp_done`. In the cycle after `dp_done` it writes address 2k with `res_wr_imag`=0, then address 2k+1 with `res_wr_imag`=1. The next band's first butterfly follows in the next cycle. `dp_done` outside this wait has no effect.
- R8: `start` while idle starts band 0 on the next cycle. `busy` stays high until the final imaginary write. `done` is then a one-cycle pulse with `busy`=0. `start` while busy has no effect.
- R9: While idle, `io_smp_wr` gives `smp_wr_en`=1 at `smp_wr_addr`. The address rises by 1 per write from 0 and wraps after FRAME_LEN−1. `io_res_rd` works the same way on `res_rd_addr`, which wraps after 2·NUM_BANDS−1. An accepted `start` clears both addresses to 0.
- R10: While busy, `io_smp_wr` and `io_res_rd` give no enable and leave both I/O addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin analysis of the stored frame |
| dp_done | input | 1 | Datapath has finished accumulating the current band |
| io_smp_wr | input | 1 | Request to write the next frame sample |
| io_res_rd | input | 1 | Request to read the next result word |
| busy | output | 1 | Compute mode active |
| done | output | 1 | One-cycle pulse after the final band's results are written |
| smp_rd_en | output | 1 | Input-RAM read / butterfly issue strobe |
| smp_addr_a | output | 8 | Forward sample index n |
| smp_addr_b | output | 8 | Mirrored sample index N−n, 0 when unused |
| smp_pair | output | 1 | Both indices valid; otherwise the datapath uses zero as partner |
| dp_first | output | 1 | First butterfly of a band (clear accumulators) |
| dp_last | output | 1 | Last butterfly of a band |
| coef_en | output | 1 | Coefficient ROM read strobe |
| coef_addr | output | 11 | Coefficient ROM address |
| res_wr_en | output | 1 | Result-RAM write strobe |
| res_wr_addr | output | 6 | Result-RAM write address |
| res_wr_imag | output | 1 | Write carries the imaginary part |
| smp_wr_en | output | 1 | Input-RAM write strobe (I/O mode) |
| smp_wr_addr | output | 8 | Input-RAM write address (I/O mode) |
| res_rd_en | output | 1 | Result-RAM read strobe (I/O mode) |
| res_rd_addr | output | 6 | Result-RAM read address (I/O mode) |

## Verification
A full frame is run with all default bands. Its odd-length and even-length windows separate a correct final butterfly, either a pair or a lone middle sample, from one that confuses the two cases. The constant-length bands and the shrinking bands together show whether the coefficient base accumulates across bands rather than restarting. The datapath's completion is held back for several cycles, and during a band `start`, `dp_done` and both I/O strobes are pulsed. This exposes any early write-back, restart or stray I/O access. I/O writes and reads are run past the frame and result depths to show wrap-around and the clear on `start`.

// File: rtl/cbt_seq_pkg.sv
// Shared types and elaboration-time band geometry for the band sequencer.
// Assumes all window lengths fit the sample RAM depth.
package cbt_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT,
        ST_WR_RE,
        ST_WR_IM
    } seq_state_t;

    // Window length of band k: constant group first, then geometric shrink.
    function automatic int win_length(input int k, input int cw_bands,
                                      input int cw_len, input int cq_first,
                                      input int r_num, input int r_den);
        int len;
        if (k < cw_bands) begin
            len = cw_len;
        end else begin
            len = cq_first;
            for (int i = cw_bands; i < k; i++) begin
                len = (len * r_num) / r_den;
            end
        end
        return len;
    endfunction

    // Coefficient base of band k: butterflies used by all earlier bands.
    function automatic int coef_base_of(input int k, input int cw_bands,
                                        input int cw_len, input int cq_first,
                                        input int r_num, input int r_den);
        int acc;
        acc = 0;
        for (int j = 0; j < k; j++) begin
            acc = acc + win_length(j, cw_bands, cw_len, cq_first, r_num, r_den) / 2 + 1;
        end
        return acc;
    endfunction

endpackage

// File: rtl/cbt_band_table.sv
// Per-band parameter table: window length, butterfly count, coefficient base.
// Contents are computed at elaboration; the lookup is purely combinational.
module cbt_band_table #(
    parameter int NUM_BANDS    = 21,
    parameter int CW_BANDS     = 5,
    parameter int CW_LEN       = 160,
    parameter int CQ_FIRST_LEN = 158,
    parameter int RATIO_NUM    = 15,
    parameter int RATIO_DEN    = 16,
    parameter int LEN_W        = 8,
    parameter int BF_W         = 7,
    parameter int COEF_AW      = 11,
    parameter int BAND_W       = 5
) (
    input  logic [BAND_W-1:0]  band_idx,
    output logic [LEN_W-1:0]   win_len,
    output logic [BF_W-1:0]    bf_count,
    output logic [COEF_AW-1:0] coef_base
);
    logic [LEN_W-1:0]   len_tab [NUM_BANDS];
    logic [BF_W-1:0]    bf_tab  [NUM_BANDS];
    logic [COEF_AW-1:0] off_tab [NUM_BANDS];

    // One table entry per band, from the package geometry functions.
    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
        localparam int LEN = cbt_seq_pkg::win_length(g, CW_BANDS, CW_LEN,
                                 CQ_FIRST_LEN, RATIO_NUM, RATIO_DEN);
        localparam int OFF = cbt_seq_pkg::coef_base_of(g, CW_BANDS, CW_LEN,
                                 CQ_FIRST_LEN, RATIO_NUM, RATIO_DEN);
        assign len_tab[g] = LEN_W'(LEN);
        assign bf_tab[g]  = BF_W'(LEN / 2 + 1);
        assign off_tab[g] = COEF_AW'(OFF);
    end

    // Select the entry of the current band.
    always_comb begin
        win_len   = len_tab[band_idx];
        bf_count  = bf_tab[band_idx];
        coef_base = off_tab[band_idx];
    end
endmodule

// File: rtl/cbt_addr_gen.sv
// Butterfly address generator: converts a butterfly index within a band into
// forward/mirrored sample indices, pairing flag and coefficient address.
// Assumes bf_idx < bf_count = floor(win_len/2)+1.
module cbt_addr_gen #(
    parameter int LEN_W   = 8,
    parameter int BF_W    = 7,
    parameter int SMP_AW  = 8,
    parameter int COEF_AW = 11
) (
    input  logic [LEN_W-1:0]   win_len,
    input  logic [BF_W-1:0]    bf_count,
    input  logic [BF_W-1:0]    bf_idx,
    input  logic [COEF_AW-1:0] coef_base,
    output logic [SMP_AW-1:0]  fwd_addr,
    output logic [SMP_AW-1:0]  mir_addr,
    output logic               pair,
    output logic               first,
    output logic               last,
    output logic [COEF_AW-1:0] coef_addr
);
    logic even_len;

    // Decode position within the band and the parity-dependent pairing.
    always_comb begin
        even_len  = ~win_len[0];
        first     = (bf_idx == '0);
        last      = (bf_idx == bf_count - 1'b1);
        pair      = !first && !(last && even_len);
        fwd_addr  = SMP_AW'(bf_idx);
        mir_addr  = pair ? SMP_AW'(win_len - LEN_W'(bf_idx)) : '0;
        coef_addr = coef_base + COEF_AW'(bf_idx);
    end
endmodule

// File: rtl/cbt_wrap_counter.sv
// Sequential I/O address counter: clears, steps and wraps at LIMIT-1.
module cbt_wrap_counter #(
    parameter int LIMIT = 160,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] value
);
    // Clear takes priority over stepping; wrap back to zero at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            value <= '0;
        end else if (step) begin
            value <= (value == W'(LIMIT - 1)) ? '0 : value + 1'b1;
        end
    end
endmodule

// File: rtl/cbt_band_sequencer.sv
// Critical-band analysis sequencer (top). Walks every band over the stored
// frame, issues one butterfly per cycle, waits for the datapath to finish,
// writes two result words per band. When idle, serves sequential I/O
// addresses. Assumes dp_done arrives only after the band's last butterfly.
module cbt_band_sequencer #(
    parameter int NUM_BANDS    = 21,
    parameter int FRAME_LEN    = 160,
    parameter int COEF_DEPTH   = 1766,
    parameter int CW_BANDS     = 5,
    parameter int CW_LEN       = 160,
    parameter int CQ_FIRST_LEN = 158,
    parameter int RATIO_NUM    = 15,
    parameter int RATIO_DEN    = 16,
    localparam int SMP_AW  = $clog2(FRAME_LEN),
    localparam int COEF_AW = $clog2(COEF_DEPTH),
    localparam int RES_AW  = $clog2(2 * NUM_BANDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               dp_done,
    input  logic               io_smp_wr,
    input  logic               io_res_rd,
    output logic               busy,
    output logic               done,
    output logic               smp_rd_en,
    output logic [SMP_AW-1:0]  smp_addr_a,
    output logic [SMP_AW-1:0]  smp_addr_b,
    output logic               smp_pair,
    output logic               dp_first,
    output logic               dp_last,
    output logic               coef_en,
    output logic [COEF_AW-1:0] coef_addr,
    output logic               res_wr_en,
    output logic [RES_AW-1:0]  res_wr_addr,
    output logic               res_wr_imag,
    output logic               smp_wr_en,
    output logic [SMP_AW-1:0]  smp_wr_addr,
    output logic               res_rd_en,
    output logic [RES_AW-1:0]  res_rd_addr
);
    import cbt_seq_pkg::*;

    localparam int LEN_W  = $clog2(FRAME_LEN + 1);
    localparam int BF_W   = $clog2(FRAME_LEN / 2 + 2);
    localparam int BAND_W = $clog2(NUM_BANDS);

    seq_state_t          state_q;
    logic [BAND_W-1:0]   band_q;
    logic [BF_W-1:0]     bf_q;
    logic                done_q;
    logic [LEN_W-1:0]    win_len;
    logic [BF_W-1:0]     bf_count;
    logic [COEF_AW-1:0]  coef_base;
    logic [SMP_AW-1:0]   ag_fwd, ag_mir;
    logic                ag_pair, ag_first, ag_last;
    logic [COEF_AW-1:0]  ag_coef;
    logic                running, accept_start;

    cbt_band_table #(
        .NUM_BANDS(NUM_BANDS), .CW_BANDS(CW_BANDS), .CW_LEN(CW_LEN),
        .CQ_FIRST_LEN(CQ_FIRST_LEN), .RATIO_NUM(RATIO_NUM), .RATIO_DEN(RATIO_DEN),
        .LEN_W(LEN_W), .BF_W(BF_W), .COEF_AW(COEF_AW), .BAND_W(BAND_W)
    ) u_table (
        .band_idx(band_q), .win_len(win_len), .bf_count(bf_count), .coef_base(coef_base)
    );

    cbt_addr_gen #(
        .LEN_W(LEN_W), .BF_W(BF_W), .SMP_AW(SMP_AW), .COEF_AW(COEF_AW)
    ) u_agen (
        .win_len(win_len), .bf_count(bf_count), .bf_idx(bf_q), .coef_base(coef_base),
        .fwd_addr(ag_fwd), .mir_addr(ag_mir), .pair(ag_pair),
        .first(ag_first), .last(ag_last), .coef_addr(ag_coef)
    );

    // Band/butterfly walk: issue, wait for datapath, write back, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            band_q  <= '0;
            bf_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_RUN;
                    band_q  <= '0;
                    bf_q    <= '0;
                end
                ST_RUN: begin
                    if (ag_last) state_q <= ST_WAIT;
                    else         bf_q    <= bf_q + 1'b1;
                end
                ST_WAIT: if (dp_done) state_q <= ST_WR_RE;
                ST_WR_RE: state_q <= ST_WR_IM;
                ST_WR_IM: begin
                    bf_q <= '0;
                    if (band_q == BAND_W'(NUM_BANDS - 1)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        band_q  <= band_q + 1'b1;
                        state_q <= ST_RUN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Compute-mode outputs, gated to zero outside the butterfly phase.
    always_comb begin
        running      = (state_q == ST_RUN);
        busy         = (state_q != ST_IDLE);
        done         = done_q;
        smp_rd_en    = running;
        coef_en      = running;
        dp_first     = running && ag_first;
        dp_last      = running && ag_last;
        smp_pair     = running && ag_pair;
        smp_addr_a   = running ? ag_fwd  : '0;
        smp_addr_b   = running ? ag_mir  : '0;
        coef_addr    = running ? ag_coef : '0;
        res_wr_en    = (state_q == ST_WR_RE) || (state_q == ST_WR_IM);
        res_wr_imag  = (state_q == ST_WR_IM);
        res_wr_addr  = RES_AW'({band_q, res_wr_imag});
        accept_start = start && !busy;
        smp_wr_en    = io_smp_wr && !busy;
        res_rd_en    = io_res_rd && !busy;
    end

    cbt_wrap_counter #(.LIMIT(FRAME_LEN), .W(SMP_AW)) u_smp_io (
        .clk(clk), .rst_n(rst_n), .clear(accept_start), .step(smp_wr_en), .value(smp_wr_addr)
    );

    cbt_wrap_counter #(.LIMIT(2 * NUM_BANDS), .W(RES_AW)) u_res_io (
        .clk(clk), .rst_n(rst_n), .clear(accept_start), .step(res_rd_en), .value(res_rd_addr)
    );

    // R3: a band opens with a lone x[0] read.
    a_r3_first_unpaired: assert property (@(posedge clk) disable iff (!rst_n)
        dp_first |-> (!smp_pair && smp_addr_a == '0));

    // R4: forward index advances by one between butterflies of a band.
    a_r4_forward_step: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_rd_en && !dp_last) |=> (smp_rd_en && smp_addr_a == $past(smp_addr_a) + 1'b1));

    // R4: mirrored index always lies above the forward one.
    a_r4_mirror_above: assert property (@(posedge clk) disable iff (!rst_n)
        smp_pair |-> (smp_addr_b > smp_addr_a));

    // R6: coefficient address steps once per butterfly.
    a_r6_coef_step: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_rd_en && !dp_last) |=> (coef_addr == $past(coef_addr) + 1'b1));

    // R7: real write is always followed by the imaginary write.
    a_r7_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wr_en && !res_wr_imag) |=> (res_wr_en && res_wr_imag));

    // R8: completion pulse only with the block idle.
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: no I/O access during compute.
    a_r10_io_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!smp_wr_en && !res_rd_en));
endmodule

// File: tb/cbt_band_sequencer_test.sv
`timescale 1ns/1ps
module cbt_band_sequencer_test;
    localparam int NB   = 21;
    localparam int FLEN = 160;
    localparam int NRES = 2 * NB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, dp_done = 1'b0, io_smp_wr = 1'b0, io_res_rd = 1'b0;
    logic       busy, done, smp_rd_en, smp_pair, dp_first, dp_last, coef_en;
    logic       res_wr_en, res_wr_imag, smp_wr_en, res_rd_en;
    logic [7:0] smp_addr_a, smp_addr_b, smp_wr_addr;
    logic [10:0] coef_addr;
    logic [5:0] res_wr_addr, res_rd_addr;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    cbt_band_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dp_done(dp_done),
        .io_smp_wr(io_smp_wr), .io_res_rd(io_res_rd), .busy(busy), .done(done),
        .smp_rd_en(smp_rd_en), .smp_addr_a(smp_addr_a), .smp_addr_b(smp_addr_b),
        .smp_pair(smp_pair), .dp_first(dp_first), .dp_last(dp_last),
        .coef_en(coef_en), .coef_addr(coef_addr), .res_wr_en(res_wr_en),
        .res_wr_addr(res_wr_addr), .res_wr_imag(res_wr_imag), .smp_wr_en(smp_wr_en),
        .smp_wr_addr(smp_wr_addr), .res_rd_en(res_rd_en), .res_rd_addr(res_rd_addr)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected window length per requirement R2.
    function automatic int exp_len(input int k);
        int l;
        if (k < 5) return 160;
        l = 158;
        for (int i = 5; i < k; i++) l = l * 15 / 16;
        return l;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "smp_rd_en", smp_rd_en, 0);
        chk("R1", "coef_en", coef_en, 0);
        chk("R1", "res_wr_en", res_wr_en, 0);
        chk("R1", "smp_wr_en", smp_wr_en, 0);
        chk("R1", "res_rd_en", res_rd_en, 0);
        chk("R1", "smp_wr_addr", smp_wr_addr, 0);
        chk("R1", "res_rd_addr", res_rd_addr, 0);
    endtask

    // I/O mode: sample writes past the frame depth, result reads past depth.
    task automatic test_io_mode(input int nwr, input int nrd);
        for (int i = 0; i < nwr; i++) begin
            io_smp_wr = 1'b1;
            #1;
            chk("R9", "smp_wr_en", smp_wr_en, 1);
            chk("R9", "smp_wr_addr", smp_wr_addr, i % FLEN);
            chk("R10", "coef_en idle", coef_en, 0);
            @(negedge clk);
        end
        io_smp_wr = 1'b0;
        for (int i = 0; i < nrd; i++) begin
            io_res_rd = 1'b1;
            #1;
            chk("R9", "res_rd_en", res_rd_en, 1);
            chk("R9", "res_rd_addr", res_rd_addr, i % NRES);
            @(negedge clk);
        end
        io_res_rd = 1'b0;
        #1;
        chk("R9", "smp_wr_en off", smp_wr_en, 0);
    endtask

    // Full frame in compute mode, with stray inputs injected in band 1.
    task automatic test_frame(input int wait_cycles);
        int coef;
        coef = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < NB; k++) begin
            int n, nb;
            n  = exp_len(k);
            nb = n / 2 + 1;
            for (int b = 0; b < nb; b++) begin
                int ea, eb, ep;
                ea = b;
                ep = (b != 0) && !((b == nb - 1) && (n % 2 == 0));
                eb = ep ? n - b : 0;
                chk("R8", "busy", busy, 1);
                chk("R2", "smp_rd_en", smp_rd_en, 1);
                chk(b == 0 ? "R3" : (b == nb - 1 ? "R5" : "R4"), "smp_addr_a", smp_addr_a, ea);
                chk(b == 0 ? "R3" : (b == nb - 1 ? "R5" : "R4"), "smp_addr_b", smp_addr_b, eb);
                chk(b == 0 ? "R3" : (b == nb - 1 ? "R5" : "R4"), "smp_pair", smp_pair, ep);
                chk("R3", "dp_first", dp_first, b == 0);
                chk("R5", "dp_last", dp_last, b == nb - 1);
                chk("R6", "coef_addr", coef_addr, coef);
                chk("R6", "coef_en", coef_en, 1);
                coef++;
                if (k == 1 && b == 5) begin
                    start = 1'b1; dp_done = 1'b1; io_smp_wr = 1'b1; io_res_rd = 1'b1;
                    #1;
                    chk("R10", "smp_wr_en busy", smp_wr_en, 0);
                    chk("R10", "res_rd_en busy", res_rd_en, 0);
                end
                @(negedge clk);
                start = 1'b0; dp_done = 1'b0; io_smp_wr = 1'b0; io_res_rd = 1'b0;
            end
            for (int w = 0; w < wait_cycles; w++) begin
                chk("R7", "wait rd_en", smp_rd_en, 0);
                chk("R7", "wait wr_en", res_wr_en, 0);
                chk("R6", "wait coef_en", coef_en, 0);
                @(negedge clk);
            end
            dp_done = 1'b1;
            @(negedge clk);
            dp_done = 1'b0;
            chk("R7", "real wr_en", res_wr_en, 1);
            chk("R7", "real addr", res_wr_addr, 2 * k);
            chk("R7", "real imag flag", res_wr_imag, 0);
            @(negedge clk);
            chk("R7", "imag wr_en", res_wr_en, 1);
            chk("R7", "imag addr", res_wr_addr, 2 * k + 1);
            chk("R7", "imag flag", res_wr_imag, 1);
            chk("R8", "done before end", done, 0);
            @(negedge clk);
        end
        chk("R8", "done pulse", done, 1);
        chk("R8", "busy end", busy, 0);
        chk("R10", "smp_wr_addr kept", smp_wr_addr, 0);
        chk("R10", "res_rd_addr kept", res_rd_addr, 0);
        @(negedge clk);
        chk("R8", "done single", done, 0);
        chk("R8", "stays idle", smp_rd_en, 0);
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        test_reset();
        test_io_mode(FLEN + 3, NRES + 2);
        test_frame(3);
        test_io_mode(4, 3);
        test_frame(0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule